// File: doc/BRIEF.md
# Transmit Interrupt Delay Timer

This block holds back transmit-completion interrupts so that several descriptor write-backs can share one interrupt. It watches a one-cycle pulse that marks a completed descriptor write-back, along with two flags carried by that descriptor: one that asks for a completion report and one that allows the report to be delayed. A write-back that asks for a report and allows delay arms a countdown if the timer is idle. When the countdown expires, the block raises a one-cycle interrupt event and, in the same cycle, a one-cycle request to flush any write-backs that have built up.

The countdown is measured in ticks of 1.024 µs. A free-running prescaler makes one tick every `TICK_DIV` core clocks, where `TICK_DIV` is the clock frequency in MHz times 1.024, rounded to an integer. Software programs the delay through a 32-bit register write port. Only the lower 16 bits are stored. A programmed value of zero is illegal, so the block replaces it with one and raises an error flag. A write-back that asks for a report but does not allow delay bypasses the timer: it raises the interrupt on the next cycle and cancels any countdown in progress.

Top module: `txint_coalesce_timer`

## Requirements
- R1: The prescaler ticks once every `TICK_DIV` clocks. Counting the reset edge as edge 0, the ticks are sampled at edges `TICK_DIV`, `2*TICK_DIV`, and so on. Each sampled tick decrements a running countdown by one.
- R2: Only a write-back that has `wb_valid`, `wb_rs` and `wb_ide` all high can start the countdown. A pulse with `wb_rs` low, or with `wb_valid` low, produces no interrupt.
- R3: The delay register keeps bits 15:0 of the written word. `reg_rd_data` bits 31:16 always read 0. A write whose bits 15:0 are zero stores 1 and sets `zero_wr_err`. A later write with a nonzero low half clears `zero_wr_err`.
- R4: The first qualifying write-back seen while the timer is idle loads the stored delay D. Qualifying write-backs that arrive while the countdown is running do not reload it.
- R5: On expiry, `flush_req` is high for exactly one cycle, in the same cycle as `txdw_irq`.
- R6: Suppose the start write-back is sampled at edge s. Expiry happens on the edge that samples the D-th tick strictly after s. `txdw_irq` is high for the one cycle that follows that edge.
- R7: A write-back with `wb_valid` and `wb_rs` high and `wb_ide` low raises `txdw_irq` on the cycle after it is sampled, without `flush_req`. It also cancels any running countdown, which then never fires.
- R8: After expiry the timer is idle, and the next qualifying write-back starts a fresh countdown.
- R9: A register write made while the countdown runs does not change that countdown. It takes effect at the next countdown start.
- R10: After reset, `txdw_irq`, `flush_req` and `zero_wr_err` are 0, and the delay register reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Delay register write strobe |
| reg_wr_data | input | 32 | Delay register write word |
| reg_rd_data | output | 32 | Delay register read value, upper half zero |
| zero_wr_err | output | 1 | Set by an illegal zero delay write |
| wb_valid | input | 1 | One-cycle descriptor write-back pulse |
| wb_rs | input | 1 | Descriptor asks for a completion report |
| wb_ide | input | 1 | Descriptor allows the report to be delayed |
| txdw_irq | output | 1 | One-cycle descriptor-written-back interrupt event |
| flush_req | output | 1 | One-cycle flush request for accumulated write-backs |

## Verification
The assertions assume that `TICK_DIV` is at least 2 and that write-back pulses follow the documented usage. In particular, a qualifying write-back never lands on the very edge where the countdown expires, and the delay register is rewritten only between complete write and wait steps. The bench meets these assumptions by driving every input one nanosecond after a clock edge. It also places each write-back pulse and register write at a cycle it has chosen, well away from any expiry it has predicted, and keeps the prescaler divisor small so that exact expiry edges can be predicted.

// File: rtl/txint_pkg.sv
package txint_pkg;

    localparam int DLY_W = 16;
    localparam int REG_W = 32;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic valid;
        logic rs;
        logic ide;
    } wb_flags_t;

    function automatic logic wb_arms(input wb_flags_t f);
        return f.valid & f.rs & f.ide;
    endfunction

    function automatic logic wb_bypass(input wb_flags_t f);
        return f.valid & f.rs & ~f.ide;
    endfunction

    function automatic logic [DLY_W-1:0] legal_delay(input logic [DLY_W-1:0] v);
        return (v == '0) ? DLY_W'(1) : v;
    endfunction

endpackage

// File: rtl/txint_tick_gen.sv
module txint_tick_gen #(
    parameter int TICK_DIV = 256
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/txint_delay_reg.sv
module txint_delay_reg
    import txint_pkg::*;
#(
    parameter logic [DLY_W-1:0] DLY_RST = 16'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [DLY_W-1:0] dly_q,
    output logic             zero_err,
    output logic [REG_W-1:0] rd_data
);
    logic [DLY_W-1:0] low_half;

    assign low_half = wr_data[DLY_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q    <= legal_delay(DLY_RST);
            zero_err <= 1'b0;
        end else if (wr_en) begin
            dly_q    <= legal_delay(low_half);
            zero_err <= (low_half == '0);
        end
    end

    assign rd_data = {{(REG_W-DLY_W){1'b0}}, dly_q};

endmodule

// File: rtl/txint_delay_ctr.sv
module txint_delay_ctr
    import txint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  wb_flags_t        wb,
    input  logic [DLY_W-1:0] dly,
    output tmr_state_e       state,
    output logic [DLY_W-1:0] remain,
    output logic             irq,
    output logic             flush
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TMR_IDLE;
            remain <= '0;
            irq    <= 1'b0;
            flush  <= 1'b0;
        end else begin
            irq   <= 1'b0;
            flush <= 1'b0;
            if (wb_bypass(wb)) begin
                irq   <= 1'b1;
                state <= TMR_IDLE;
            end else begin
                unique case (state)
                    TMR_IDLE: begin
                        if (wb_arms(wb)) begin
                            remain <= dly;
                            state  <= TMR_RUN;
                        end
                    end
                    TMR_RUN: begin
                        if (tick) begin
                            if (remain <= DLY_W'(1)) begin
                                irq   <= 1'b1;
                                flush <= 1'b1;
                                state <= TMR_IDLE;
                            end else begin
                                remain <= remain - 1'b1;
                            end
                        end
                    end
                    default: state <= TMR_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/txint_coalesce_timer.sv
module txint_coalesce_timer
    import txint_pkg::*;
#(
    parameter int TICK_DIV = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        zero_wr_err,
    input  logic        wb_valid,
    input  logic        wb_rs,
    input  logic        wb_ide,
    output logic        txdw_irq,
    output logic        flush_req
);
    logic             tick;
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] remain;
    tmr_state_e       state;
    wb_flags_t        wb;

    assign wb = '{valid: wb_valid, rs: wb_rs, ide: wb_ide};

    txint_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    txint_delay_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .dly_q    (dly_q),
        .zero_err (zero_wr_err),
        .rd_data  (reg_rd_data)
    );

    txint_delay_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .wb     (wb),
        .dly    (dly_q),
        .state  (state),
        .remain (remain),
        .irq    (txdw_irq),
        .flush  (flush_req)
    );

endmodule

// File: rtl/txint_coalesce_timer_chk.sv
module txint_coalesce_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic [31:0] reg_wr_data,
    input logic [31:0] reg_rd_data,
    input logic        zero_wr_err,
    input logic        wb_valid,
    input logic        wb_rs,
    input logic        wb_ide,
    input logic        txdw_irq,
    input logic        flush_req,
    input logic        tick,
    input logic        state,
    input logic [15:0] remain
);
    // R1: expiry only follows a sampled prescaler tick
    a_r1_flush_after_tick: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> $past(tick));

    // R3: zero write is replaced by one and flagged
    a_r3_zero_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_data[15:0] == 16'd0) |=> (zero_wr_err && reg_rd_data == 32'd1));

    // R3: stored delay is never zero and upper half reads zero
    a_r3_legal_read: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[15:0] != 16'd0) && (reg_rd_data[31:16] == 16'd0));

    // R4: a running countdown holds between ticks, whatever write-backs arrive
    a_r4_no_reload: assert property (@(posedge clk) disable iff (rst)
        (state && !tick && !(wb_valid && wb_rs && !wb_ide)) |=> $stable(remain));

    // R5: flush coincides with the interrupt
    a_r5_flush_with_irq: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> txdw_irq);

    // R5: flush lasts one cycle
    a_r5_flush_single: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !flush_req);

    // R7: bypass write-back interrupts next cycle without flush
    a_r7_bypass: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_rs && !wb_ide) |=> (txdw_irq && !flush_req && !state));
endmodule

bind txint_coalesce_timer txint_coalesce_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .zero_wr_err (zero_wr_err),
    .wb_valid    (wb_valid),
    .wb_rs       (wb_rs),
    .wb_ide      (wb_ide),
    .txdw_irq    (txdw_irq),
    .flush_req   (flush_req),
    .tick        (tick),
    .state       (state),
    .remain      (remain)
);

// File: tb/txint_coalesce_timer_tb.sv
module txint_coalesce_timer_tb;
    localparam int DIV = 4;
    localparam int NV  = 6;
    // each entry: {delay[31:16], lead cycles after write[15:0]}
    localparam logic [31:0] VEC [NV] = '{
        {16'd1, 16'd0}, {16'd1, 16'd3}, {16'd2, 16'd1},
        {16'd3, 16'd2}, {16'd5, 16'd5}, {16'd4, 16'd6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        zero_wr_err;
    logic        wb_valid = 1'b0, wb_rs = 1'b0, wb_ide = 1'b0;
    logic        txdw_irq, flush_req;
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    txint_coalesce_timer #(.TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .zero_wr_err(zero_wr_err), .wb_valid(wb_valid),
        .wb_rs(wb_rs), .wb_ide(wb_ide), .txdw_irq(txdw_irq), .flush_req(flush_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic reg_write(input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_wr_data = '0;
    endtask

    // drives a one-cycle write-back; returns the edge count current at drive
    task automatic wb_pulse(input logic rs, input logic ide, input logic v, output int w);
        w = cyc;
        wb_valid = v; wb_rs = rs; wb_ide = ide;
        @(posedge clk); #1;
        wb_valid = 1'b0; wb_rs = 1'b0; wb_ide = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic wait_irq(input int lim, output bit seen, output int at, output bit fl);
        seen = 0; at = -1; fl = 0;
        for (int i = 0; i < lim && !seen; i++) begin
            @(posedge clk); #1;
            if (txdw_irq) begin seen = 1; at = cyc; fl = flush_req; end
        end
    endtask

    // R1/R6: edge sampling the D-th tick after start edge s = w+1
    function automatic int exp_edge(input int w, input int d);
        int s = w + 1;
        return ((s / DIV) + 1) * DIV + (d - 1) * DIV;
    endfunction

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w, w2, at;
        bit seen, fl;
        do_reset();
        // R10 reset state
        chk("R10 irq", int'(txdw_irq), 0);
        chk("R10 flush", int'(flush_req), 0);
        chk("R10 err", int'(zero_wr_err), 0);
        chk("R10 rd", int'(reg_rd_data), 1);

        // vector table: R1 / R6 / R5 timing over several phases and delays
        for (int k = 0; k < NV; k++) begin
            do_reset();
            reg_write({16'h0, VEC[k][31:16]});
            idle(int'(VEC[k][15:0]));
            wb_pulse(1'b1, 1'b1, 1'b1, w);
            wait_irq(200, seen, at, fl);
            chk("R6 expiry edge", at, exp_edge(w, int'(VEC[k][31:16])));
            chk("R5 flush with irq", int'(fl), 1);
            idle(1); #0;
            chk("R5 flush one cycle", int'(flush_req), 0);
            chk("R6 irq one cycle", int'(txdw_irq), 0);
        end

        // R3 register behaviour
        do_reset();
        reg_write(32'hABCD_0007);
        chk("R3 upper ignored", int'(reg_rd_data), 7);
        chk("R3 no err", int'(zero_wr_err), 0);
        reg_write(32'h0001_0000);
        chk("R3 zero becomes one", int'(reg_rd_data), 1);
        chk("R3 err set", int'(zero_wr_err), 1);
        reg_write(32'h0000_0005);
        chk("R3 err cleared", int'(zero_wr_err), 0);

        // R2 non-qualifying write-backs
        do_reset();
        reg_write(32'd1);
        wb_pulse(1'b0, 1'b1, 1'b1, w);
        wait_irq(30, seen, at, fl);
        chk("R2 rs low no irq", int'(seen), 0);
        wb_pulse(1'b1, 1'b1, 1'b0, w);
        wait_irq(30, seen, at, fl);
        chk("R2 valid low no irq", int'(seen), 0);

        // R4 later qualifying write-back does not reload
        do_reset();
        reg_write(32'd3);
        wb_pulse(1'b1, 1'b1, 1'b1, w);
        idle(2);
        wb_pulse(1'b1, 1'b1, 1'b1, w2);
        wait_irq(100, seen, at, fl);
        chk("R4 no reload", at, exp_edge(w, 3));

        // R7 bypass while idle, then cancellation of a running countdown
        do_reset();
        reg_write(32'd5);
        wb_pulse(1'b1, 1'b0, 1'b1, w);
        chk("R7 idle bypass irq", int'(txdw_irq), 1);
        chk("R7 idle bypass no flush", int'(flush_req), 0);
        wb_pulse(1'b1, 1'b1, 1'b1, w);
        idle(3);
        wb_pulse(1'b1, 1'b0, 1'b1, w2);
        chk("R7 run bypass irq", int'(txdw_irq), 1);
        chk("R7 run bypass no flush", int'(flush_req), 0);
        wait_irq(60, seen, at, fl);
        chk("R7 countdown cancelled", int'(seen), 0);

        // R9 write during run, R8 restart after expiry
        do_reset();
        reg_write(32'd2);
        wb_pulse(1'b1, 1'b1, 1'b1, w);
        reg_write(32'd6);
        wait_irq(100, seen, at, fl);
        chk("R9 running count unchanged", at, exp_edge(w, 2));
        idle(2);
        wb_pulse(1'b1, 1'b1, 1'b1, w);
        wait_irq(200, seen, at, fl);
        chk("R8 restart uses new delay R9", at, exp_edge(w, 6));
        chk("R8 restart flush", int'(fl), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule